// File: doc/BRIEF.md
# Loopable Test Command Sequencer

This block stores a short list of command words loaded by software and plays them onto the downstream command bus. It stands in for the upstream controller when none is attached. While the block is idle or waiting to start, live link words pass through to the output. Once playback starts, a source multiplexer hands the output to the stored list, either for one pass or for an endless loop.

Each stored entry carries a data word and an end-of-command bit. The output never switches source in the middle of a command, so neither side sees a command that has been cut short. Loop mode replays the list until software stops it, which makes long error-rate runs possible. A wrap counter reports how many full passes have been sent. Writes to the entry store and to the length register are ignored while playback is busy.

Top module: `cmd_seq_top`

## Requirements
- R1: After reset, `out_valid`, `out_from_seq`, `busy` and `done` are 0, `loop_count` is 0 and the stored length is 0.
- R2: While the block is not playing, a link word presented with `link_valid` high appears on `out_data`/`out_last` with `out_valid` high and `out_from_seq` low one cycle later.
- R3: `start` is accepted only when the block is idle and the stored length is nonzero. Acceptance raises `busy`, clears `done` and `loop_count`, and captures `loop_mode`. A `start` with length 0 leaves `busy` low.
- R4: Playback takes over the output only at a link command boundary. A link command is open from a valid word with `link_last` low until a valid word with `link_last` high. With the link idle, stored entry 0 appears on the output three cycles after the `start` cycle.
- R5: During playback, entries 0 to L-1 are sent in order, one per cycle, with `out_valid` and `out_from_seq` high. `out_last` equals the stored end-of-command bit.
- R6: In single-shot mode, `done` rises and `busy` falls in the same cycle as the output of entry L-1.
- R7: In loop mode, entry 0 follows entry L-1. `loop_count` rises by one in the cycle entry L-1 is output and wraps modulo 2^CNT_W.
- R8: A `stop` pulse during playback ends it with the first word output at or after the stop cycle whose end-of-command bit is 1. `busy` falls in that word's cycle and `done` stays 0. A `stop` while waiting for a link boundary returns the block to idle with no stored word sent.
- R9: Entry writes (`wr_en`) and length writes (`len_en`) made while `busy` is high do not change the stored entries or length.
- R10: A length write above DEPTH stores DEPTH.
- R11: Link words that arrive during playback are dropped and never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one stored entry |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | DW | Command word to store |
| wr_eoc | input | 1 | End-of-command bit to store |
| len_en | input | 1 | Write the sequence length |
| len_val | input | AW+1 | Number of valid entries |
| start | input | 1 | Begin playback |
| stop | input | 1 | End playback at the next command end |
| loop_mode | input | 1 | 1 = loop, 0 = single pass; captured at start |
| link_valid | input | 1 | Live link word valid |
| link_data | input | DW | Live link word |
| link_last | input | 1 | Live link word ends a command |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output command word |
| out_last | output | 1 | Output word ends a command |
| out_from_seq | output | 1 | Output word comes from the stored list |
| busy | output | 1 | Armed or playing |
| done | output | 1 | Single pass completed |
| loop_count | output | CNT_W | Completed passes in loop mode |

## Verification
The bench builds the block with DEPTH=8, DW=12 and CNT_W=4. A 4-bit counter lets a one-entry loop wrap `loop_count` within about twenty cycles. Eight entries keep full-length runs and the above-DEPTH length clamp cheap to reach. Random lengths, end-of-command patterns, stop points and blocked writes during playback are mixed with directed cases: a zero length, a start while a link command is open, and a stop while waiting for the boundary.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_PLAY = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cmd_seq_store.sv
module cmd_seq_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_eoc,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_eoc
);
    localparam int EW = DW + 1;

    logic [EW-1:0] mem_q [DEPTH];

    // entry format: end-of-command bit above the data word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= {wr_eoc, wr_data};
        end
    end

    assign rd_data = mem_q[rd_addr][DW-1:0];
    assign rd_eoc  = mem_q[rd_addr][DW];
endmodule

// File: rtl/cmd_seq_link_mon.sv
module cmd_seq_link_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic link_valid,
    input  logic link_last,
    output logic open_d,
    output logic open_q
);
    // open: a link command has started and its last word has not yet been seen
    always_comb begin
        open_d = open_q;
        if (link_valid) begin
            open_d = ~link_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
    import cmd_seq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_en,
    input  logic [LW-1:0]    len_val,
    input  logic             start,
    input  logic             stop,
    input  logic             loop_mode,
    input  logic             link_valid,
    input  logic [DW-1:0]    link_data,
    input  logic             link_last,
    input  logic             link_open_d,
    input  logic [DW-1:0]    rd_data,
    input  logic             rd_eoc,
    output logic [AW-1:0]    rd_addr,
    output logic             wr_allow,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             out_from_seq,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] loop_count
);
    localparam logic [LW-1:0] LEN_MAX = LW'(DEPTH);
    localparam logic [LW-1:0] LEN_ONE = LW'(1);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    ptr;
        logic [LW-1:0]    len;
        logic             loop_md;
        logic             stop_pend;
        logic             done;
        logic [CNT_W-1:0] loops;
        logic             ov;
        logic [DW-1:0]    od;
        logic             ol;
        logic             osrc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic last_ent;
    logic stop_now;

    assign last_ent = ({1'b0, ctl_q.ptr} == (ctl_q.len - LEN_ONE));
    assign stop_now = ctl_q.stop_pend | stop;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ov   = link_valid;
        ctl_d.od   = link_data;
        ctl_d.ol   = link_last;
        ctl_d.osrc = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (len_en) begin
                    ctl_d.len = (len_val > LEN_MAX) ? LEN_MAX : len_val;
                end
                if (start && (ctl_q.len != '0)) begin
                    ctl_d.st        = ST_ARM;
                    ctl_d.done      = 1'b0;
                    ctl_d.loops     = '0;
                    ctl_d.ptr       = '0;
                    ctl_d.loop_md   = loop_mode;
                    ctl_d.stop_pend = 1'b0;
                end
            end
            ST_ARM: begin
                if (stop) begin
                    ctl_d.st = ST_IDLE;
                end else if (!link_open_d) begin
                    ctl_d.st = ST_PLAY;
                end
            end
            ST_PLAY: begin
                ctl_d.ov   = 1'b1;
                ctl_d.od   = rd_data;
                ctl_d.ol   = rd_eoc;
                ctl_d.osrc = 1'b1;
                if (last_ent) begin
                    if (ctl_q.loop_md) begin
                        ctl_d.ptr   = '0;
                        ctl_d.loops = ctl_q.loops + CNT_W'(1);
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end else begin
                    ctl_d.ptr = ctl_q.ptr + PTR_ONE;
                end
                if (stop_now && rd_eoc) begin
                    ctl_d.st = ST_IDLE;
                end
                if (ctl_d.st == ST_IDLE) begin
                    ctl_d.stop_pend = 1'b0;
                end else if (stop) begin
                    ctl_d.stop_pend = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_addr      = ctl_q.ptr;
    assign wr_allow     = (ctl_q.st == ST_IDLE);
    assign busy         = (ctl_q.st != ST_IDLE);
    assign out_valid    = ctl_q.ov;
    assign out_data     = ctl_q.od;
    assign out_last     = ctl_q.ol;
    assign out_from_seq = ctl_q.osrc;
    assign done         = ctl_q.done;
    assign loop_count   = ctl_q.loops;
endmodule

// File: rtl/cmd_seq_top.sv
module cmd_seq_top #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_eoc,
    input  logic             len_en,
    input  logic [LW-1:0]    len_val,
    input  logic             start,
    input  logic             stop,
    input  logic             loop_mode,
    input  logic             link_valid,
    input  logic [DW-1:0]    link_data,
    input  logic             link_last,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             out_from_seq,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] loop_count
);
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_eoc;
    logic          wr_allow;
    logic          link_open_d;
    logic          link_open_q;
    logic          store_we;

    assign store_we = wr_en & wr_allow;

    cmd_seq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (store_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_eoc  (wr_eoc),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_eoc  (rd_eoc)
    );

    cmd_seq_link_mon u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_last  (link_last),
        .open_d     (link_open_d),
        .open_q     (link_open_q)
    );

    cmd_seq_ctrl #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW), .LW(LW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .len_en       (len_en),
        .len_val      (len_val),
        .start        (start),
        .stop         (stop),
        .loop_mode    (loop_mode),
        .link_valid   (link_valid),
        .link_data    (link_data),
        .link_last    (link_last),
        .link_open_d  (link_open_d),
        .rd_data      (rd_data),
        .rd_eoc       (rd_eoc),
        .rd_addr      (rd_addr),
        .wr_allow     (wr_allow),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_last     (out_last),
        .out_from_seq (out_from_seq),
        .busy         (busy),
        .done         (done),
        .loop_count   (loop_count)
    );

    logic unused_open_q;
    assign unused_open_q = link_open_q;
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_valid,
    input logic             link_last,
    input logic             out_valid,
    input logic             out_from_seq,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] loop_count
);
    // independent record of whether a link command is open
    logic mid_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q <= 1'b0;
        end else if (link_valid) begin
            mid_q <= ~link_last;
        end
    end

    assert_seq_word_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_from_seq |-> out_valid);

    assert_switch_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_from_seq) |-> !mid_q);

    assert_done_with_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (out_from_seq && !busy));

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_loop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_count != $past(loop_count)) |->
            ((loop_count == CNT_W'($past(loop_count) + 1'b1)) || (loop_count == '0)));

    assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!done && loop_count == '0));
endmodule

bind cmd_seq_top cmd_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_valid   (link_valid),
    .link_last    (link_last),
    .out_valid    (out_valid),
    .out_from_seq (out_from_seq),
    .busy         (busy),
    .done         (done),
    .loop_count   (loop_count)
);

// File: tb/test_cmd_seq_top.sv
module test_cmd_seq_top;
    localparam int DW    = 12;
    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int AW    = 3;
    localparam int LW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             wr_en = 0, wr_eoc = 0, len_en = 0, start = 0, stop = 0, loop_mode = 0;
    logic [AW-1:0]    wr_addr = '0;
    logic [DW-1:0]    wr_data = '0, link_data = '0;
    logic [LW-1:0]    len_val = '0;
    logic             link_valid = 0, link_last = 0;
    logic             out_valid, out_last, out_from_seq, busy, done;
    logic [DW-1:0]    out_data;
    logic [CNT_W-1:0] loop_count;

    cmd_seq_top #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_cmd_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_eoc(wr_eoc), .len_en(len_en), .len_val(len_val), .start(start), .stop(stop),
        .loop_mode(loop_mode), .link_valid(link_valid), .link_data(link_data),
        .link_last(link_last), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_from_seq(out_from_seq), .busy(busy), .done(done),
        .loop_count(loop_count)
    );

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] m_d [DEPTH];
    logic          m_e [DEPTH];
    int            m_len = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int word_of(input logic [DW-1:0] d, input logic l);
        return int'({l, d});
    endfunction

    task automatic clear_pokes();
        wr_en = 0; len_en = 0; link_valid = 0; link_last = 0;
    endtask

    task automatic program_seq(input int len, input int len_req);
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] d;
            logic e;
            d = DW'($urandom);
            e = (($urandom % 3) == 0) || (a == len - 1);
            wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_eoc = e;
            m_d[a] = d; m_e[a] = e;
            @(negedge clk);
        end
        wr_en = 0; len_en = 1; len_val = LW'(len_req);
        @(negedge clk);
        len_en = 0;
        m_len = len;
    endtask

    task automatic run_single();
        int idx = 0;
        int c = 1;
        bit ended = 0;
        loop_mode = 0; start = 1;
        @(negedge clk);
        start = 0;
        check(done == 0 && busy == 1, "R3 start clears done, raises busy", {busy, done}, 2);
        while (c < m_len + 20 && !ended) begin
            if (out_from_seq) begin
                check(word_of(out_data, out_last) == word_of(m_d[idx], m_e[idx]), "R5 stored word order",
                      word_of(out_data, out_last), word_of(m_d[idx], m_e[idx]));
                if (idx == 0) check(c == 3, "R4 first stored word latency", c, 3);
                idx++;
                if (idx == m_len) begin
                    check(done && !busy, "R6 done with final word", {busy, done}, 1);
                    ended = 1;
                end
            end
            if (!ended) begin
                @(negedge clk);
                c++;
            end
        end
        check(idx == m_len, "R6 single pass length", idx, m_len);
        @(negedge clk);
        check(!out_from_seq && done && !busy, "R6 idle after pass", {out_from_seq, busy, done}, 1);
    endtask

    task automatic run_loop(input int nwords, input bit poke);
        int idx = 0;
        int got = 0;
        int guard = 0;
        bit ended = 0;
        logic [CNT_W-1:0] lc = '0;
        loop_mode = 1; start = 1;
        @(negedge clk);
        start = 0; loop_mode = 0;
        check(loop_count == 0 && done == 0, "R3 start clears loop count", int'(loop_count), 0);
        while (!ended && guard < nwords + 4 * DEPTH + 20) begin
            stop = 0;
            if (out_from_seq) begin
                check(word_of(out_data, out_last) == word_of(m_d[idx], m_e[idx]), "R7 loop word",
                      word_of(out_data, out_last), word_of(m_d[idx], m_e[idx]));
                if (idx == m_len - 1) lc = lc + 1'b1;
                check(loop_count == lc, "R7 loop count", int'(loop_count), int'(lc));
                if (got >= nwords && m_e[idx]) begin
                    check(!busy && !done, "R8 stop at command end", {busy, done}, 0);
                    ended = 1;
                end else begin
                    check(busy, "R8 playback continues", busy, 1);
                end
                idx = (idx == m_len - 1) ? 0 : idx + 1;
                got++;
                if (got == nwords) stop = 1;
            end
            if (poke && !ended) begin
                wr_en = 1; wr_addr = AW'($urandom); wr_data = DW'($urandom); wr_eoc = 1'($urandom);
                len_en = 1; len_val = LW'($urandom);
                link_valid = 1'($urandom); link_data = DW'($urandom); link_last = 1;
            end else begin
                clear_pokes();
            end
            if (!ended) begin
                @(negedge clk);
                guard++;
            end
        end
        clear_pokes();
        stop = 0;
        check(ended, "R8 stop ended playback", ended, 1);
        @(negedge clk);
        check(!out_from_seq && !busy && !done, "R8 idle without done", {out_from_seq, busy, done}, 0);
    endtask

    task automatic run_mid_command();
        logic [DW-1:0] prev;
        int idx;
        int guard;
        prev = DW'($urandom);
        link_valid = 1; link_last = 0; link_data = prev; loop_mode = 0; start = 1;
        @(negedge clk);
        start = 0;
        check(out_data == prev && !out_from_seq, "R2 link word passes while armed", int'(out_data), int'(prev));
        for (int k = 0; k < 3; k++) begin
            prev = DW'($urandom);
            link_data = prev;
            @(negedge clk);
            check(!out_from_seq && busy && out_data == prev, "R4 held during open command",
                  int'(out_from_seq), 0);
        end
        prev = DW'($urandom);
        link_data = prev; link_last = 1;
        @(negedge clk);
        check(out_data == prev && out_last && !out_from_seq, "R4 closing link word first", int'(out_data), int'(prev));
        link_valid = 0; link_last = 0;
        @(negedge clk);
        check(out_from_seq && out_data == m_d[0], "R4 switch after boundary", int'(out_data), int'(m_d[0]));
        idx = 1;
        guard = 0;
        while (busy && guard < 40) begin
            @(negedge clk);
            guard++;
            if (out_from_seq) begin
                check(out_data == m_d[idx], "R5 word after boundary", int'(out_data), int'(m_d[idx]));
                idx++;
            end
        end
        check(idx == m_len, "R6 pass length after boundary", idx, m_len);
        @(negedge clk);
    endtask

    task automatic run_stop_armed();
        link_valid = 1; link_last = 0; link_data = DW'($urandom); start = 1;
        @(negedge clk);
        start = 0;
        check(busy, "R4 armed while link command open", busy, 1);
        stop = 1;
        @(negedge clk);
        stop = 0;
        check(!busy && !out_from_seq, "R8 stop while armed", busy, 0);
        link_last = 1;
        @(negedge clk);
        clear_pokes();
        @(negedge clk);
        check(!busy && !out_from_seq && !done, "R8 no stored word after armed stop", int'(out_from_seq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!out_valid && !out_from_seq && !busy && !done && loop_count == 0, "R1 reset state",
              {out_valid, out_from_seq, busy, done}, 0);

        // zero length: start ignored
        start = 1;
        @(negedge clk);
        start = 0;
        check(!busy, "R1 R3 zero length start ignored", busy, 0);
        @(negedge clk);
        check(!busy && !out_from_seq, "R3 still idle", busy, 0);

        // pass-through of live words
        for (int i = 0; i < 10; i++) begin
            logic [DW-1:0] d;
            logic l;
            d = DW'($urandom);
            l = (i == 9) ? 1'b1 : 1'($urandom);
            link_valid = 1; link_data = d; link_last = l;
            @(negedge clk);
            check(out_valid && !out_from_seq && word_of(out_data, out_last) == word_of(d, l),
                  "R2 link pass-through", word_of(out_data, out_last), word_of(d, l));
        end
        clear_pokes();
        @(negedge clk);

        program_seq(5, 5);
        run_single();
        run_loop(13, 1);
        run_single();   // R9: contents and length survived blocked writes; R11 link drop

        program_seq(DEPTH, DEPTH + 3);
        run_single();   // R10 clamp

        program_seq(1, 1);
        run_loop((1 << CNT_W) + 3, 0);   // R7 counter wrap

        program_seq(4, 4);
        run_mid_command();
        run_stop_armed();

        for (int r = 0; r < 8; r++) begin
            int len;
            len = 1 + int'($urandom % DEPTH);
            program_seq(len, len);
            if (($urandom % 2) == 0) run_single();
            else run_loop(1 + int'($urandom % 40), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule